// File: doc/BRIEF.md
# Ping-Pong Ancillary Word Buffer

This block holds extracted ancillary data words in a memory split into two equal halves, so that the host can read one packet batch while new words land in the other. A single control bit steers the buffer. Its level means nothing: every change of level, rising or falling, counts as one step through a fixed four-phase cycle. The phases are write-first/read-first, write-second/read-first, write-second/read-second with the first half cleared, and write-first/read-second. A step that hands a half to the writer restarts that half at address zero. A step that moves the reader empties the half it leaves.

Extraction runs only while the buffer is out of bypass and a re-enable delay has elapsed. Bypass is chosen by a two-bit mode field. Once extraction is running, dropping the enable bit does not stop it. The block raises a detect flag while words are coming in. It latches the data-count word of each packet, which is the word three places after the packet's first word. It also pulses an error output when the control bit changes too soon after the previous change, or while a packet is arriving.

Top module: `anc_pingpong_buf`

## Requirements
- R1: Every change of `switch_i`, rising or falling, advances the phase by one; the level of `switch_i` has no other effect. The change is taken at the clock edge where `switch_i` differs from its value at the previous edge.
- R2: After reset, words go to the first half and reads come from the first half. A half holds 1024 words. When it is full, `full_o[h]` is high (bit 0 = first half, bit 1 = second half), the stored contents stay unchanged and further words are dropped.
- R3: On the first step, writing moves to the second half starting at address 0, and the first half stays readable and unchanged.
- R4: On the second step, the first half is cleared and reads come from the second half. Writing continues in the second half at the next free address.
- R5: On the third step, writing moves to the first half starting at address 0, and the second half stays readable.
- R6: On the fourth step, the second half is cleared and the arrangement returns to the reset one. The cycle repeats.
- R7: `mode_i == 2'b11` (bypass) stops extraction from the next edge, and words are dropped. Clearing `ext_en_i` while extraction runs does not stop it.
- R8: After reset, or after leaving bypass, extraction starts only once 2200 cycles outside bypass have passed, and only at an edge where `ext_en_i` is high.
- R9: `err_o` pulses high for one cycle after a step taken fewer than 1100 cycles after the previous step, or while `detect_o` is high. The step still takes effect.
- R10: `detect_o` is high in the cycle after an edge where a word was presented (`valid_i`) with extraction running, and low otherwise.
- R11: `dc_o` takes the word with index 3 of a packet (index 0 is the first word of a run of `valid_i`) when that word is stored. Otherwise `dc_o` holds its value; it is 0 after reset.
- R12: Clearing a half resets its fill count and full flag in one cycle. Reads of a half return 0 at every address not written since its last clear.
- R13: `rd_data_o` shows, one cycle after `rd_addr_i` is applied, the word at that address in the half selected for reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| switch_i | input | 1 | Half-steering bit; each level change is one step |
| mode_i | input | 2 | Buffer mode; 2'b11 selects bypass |
| ext_en_i | input | 1 | Extraction enable, sampled when re-enabling |
| valid_i | input | 1 | Word strobe of the extracted stream |
| data_i | input | 10 | Extracted word |
| rd_addr_i | input | 10 | Host read address within the read half |
| rd_data_o | output | 10 | Host read data, one cycle latency |
| detect_o | output | 1 | Words are being received |
| full_o | output | 2 | Per-half full flags |
| dc_o | output | 10 | Last latched data-count word |
| err_o | output | 1 | Step rule violation pulse |

## Verification
The assertions check the following on every cycle: each step advances the phase by exactly one, and the phase holds when there is no step. A cleared half reads as empty on the next cycle, and a full half keeps its fill count. Bypass takes extraction down at the next edge, and extraction comes up only with the enable high. Detect, data-count and error pulses each follow their cause. Only the bench scenarios show that data reaches the right half at the right address across all four phases. They also show that the half being read survives the writer's moves, that stale contents of a cleared half read as zero, and that the 2200-cycle and 1100-cycle windows are counted to the right edge.

// File: rtl/anc_pkg.sv
package anc_pkg;
  typedef enum logic [1:0] {
    PH_WA_RA = 2'd0,
    PH_WB_RA = 2'd1,
    PH_WB_RB = 2'd2,
    PH_WA_RB = 2'd3
  } phase_e;

  function automatic logic wr_half(input phase_e p);
    return (p == PH_WB_RA) || (p == PH_WB_RB);
  endfunction

  function automatic logic rd_half(input phase_e p);
    return (p == PH_WB_RB) || (p == PH_WA_RB);
  endfunction
endpackage

// File: rtl/anc_toggle_ctrl.sv
module anc_toggle_ctrl
  import anc_pkg::*;
#(
  parameter int GAP = 1100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       switch_i,
  input  logic       detect_i,
  output phase_e     phase_o,
  output logic [1:0] clr_o,
  output logic       err_o
);
  localparam int GW = $clog2(GAP + 1);

  logic          sw_q;
  logic          tog;
  logic [GW-1:0] gap_q;
  phase_e        phase_q, phase_n;
  logic          err_q;

  assign tog     = switch_i ^ sw_q;
  assign phase_n = phase_e'(phase_q + 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_q    <= 1'b0;
      gap_q   <= GW'(GAP);
      phase_q <= PH_WA_RA;
      err_q   <= 1'b0;
    end else begin
      sw_q  <= switch_i;
      err_q <= tog && ((gap_q < GW'(GAP - 1)) || detect_i);
      if (tog) begin
        phase_q <= phase_n;
        gap_q   <= '0;
      end else if (gap_q != GW'(GAP)) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // entering an odd phase restarts the new write half; even phase frees the old read half
  always_comb begin
    clr_o = 2'b00;
    if (tog) begin
      unique case (phase_n)
        PH_WB_RA, PH_WA_RA: clr_o[1] = 1'b1;
        PH_WB_RB, PH_WA_RB: clr_o[0] = 1'b1;
        default:            clr_o    = 2'b00;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign err_o   = err_q;

  assert_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (switch_i != sw_q) |=> (phase_q == phase_e'($past(phase_q) + 2'd1)));
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (switch_i == sw_q) |=> $stable(phase_q));
  assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(switch_i != sw_q));
  assert_one_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
endmodule

// File: rtl/anc_ext_gate.sv
module anc_ext_gate #(
  parameter int DELAY = 2200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  output logic       active_o
);
  localparam int CW = $clog2(DELAY + 1);

  logic          bypass;
  logic [CW-1:0] cnt_q;
  logic          act_q;

  assign bypass = (mode_i == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (bypass) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      if (cnt_q != CW'(DELAY)) cnt_q <= cnt_q + 1'b1;
      // once running, enable is ignored until bypass
      if (cnt_q == CW'(DELAY) && en_i) act_q <= 1'b1;
    end
  end

  assign active_o = act_q;

  assert_bypass_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> !active_o);
  assert_start_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(en_i) && $past(cnt_q == CW'(DELAY)));
endmodule

// File: rtl/anc_half_buf.sv
module anc_half_buf #(
  parameter int AW = 10,
  parameter int DW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   cnt_q;
  logic          full;
  logic          acc;
  logic [DW-1:0] rdata_q;

  assign full = (cnt_q == (AW+1)'(DEPTH));
  assign acc  = we_i && !full && !clr_i;

  always_ff @(posedge clk_i) begin
    if (acc) mem[cnt_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (clr_i)    cnt_q <= '0;
      else if (acc) cnt_q <= cnt_q + 1'b1;
      // addresses beyond the fill count read as zero
      rdata_q <= ({1'b0, raddr_i} < cnt_q) ? mem[raddr_i] : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign full_o  = full;

  assert_clear_empties_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !full_o);
  assert_full_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !clr_i) |=> full_o && $stable(cnt_q));
  assert_no_overflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= (AW+1)'(DEPTH));
endmodule

// File: rtl/anc_pkt_tracker.sv
module anc_pkt_tracker #(
  parameter int DW     = 10,
  parameter int DC_OFS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          valid_i,
  input  logic          stored_i,
  input  logic [DW-1:0] data_i,
  output logic          detect_o,
  output logic [DW-1:0] dc_o
);
  localparam int IW = $clog2(DC_OFS + 2);

  logic          take;
  logic [IW-1:0] idx_q;
  logic          det_q;
  logic [DW-1:0] dc_q;

  assign take = active_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      det_q <= 1'b0;
      dc_q  <= '0;
    end else begin
      det_q <= take;
      if (!take)                        idx_q <= '0;
      else if (idx_q != IW'(DC_OFS + 1)) idx_q <= idx_q + 1'b1;
      if (take && stored_i && idx_q == IW'(DC_OFS)) dc_q <= data_i;
    end
  end

  assign detect_o = det_q;
  assign dc_o     = dc_q;

  assert_detect_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detect_o |-> $past(valid_i) && $past(active_i));
  assert_dc_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dc_o) |-> $past(stored_i) && $past(valid_i));
endmodule

// File: rtl/anc_pingpong_buf.sv
module anc_pingpong_buf
  import anc_pkg::*;
#(
  parameter int AW       = 10,
  parameter int DW       = 10,
  parameter int REEN_CYC = 2200,
  parameter int TOG_GAP  = 1100,
  parameter int DC_OFS   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          switch_i,
  input  logic [1:0]    mode_i,
  input  logic          ext_en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          detect_o,
  output logic [1:0]    full_o,
  output logic [DW-1:0] dc_o,
  output logic          err_o
);
  localparam int NH = 2;

  phase_e        phase;
  logic [1:0]    clr_v;
  logic          active;
  logic          wsel, rsel, rsel_q;
  logic [NH-1:0] we_v, full_v;
  logic [DW-1:0] rdata_v [NH];
  logic          stored;

  anc_toggle_ctrl #(.GAP(TOG_GAP)) u_ctrl (
    .clk_i, .rst_ni, .switch_i,
    .detect_i(detect_o),
    .phase_o (phase),
    .clr_o   (clr_v),
    .err_o   (err_o)
  );

  anc_ext_gate #(.DELAY(REEN_CYC)) u_gate (
    .clk_i, .rst_ni, .mode_i,
    .en_i    (ext_en_i),
    .active_o(active)
  );

  assign wsel = wr_half(phase);
  assign rsel = rd_half(phase);

  for (genvar h = 0; h < NH; h++) begin : g_half
    assign we_v[h] = active && valid_i && (wsel == 1'(h));
    anc_half_buf #(.AW(AW), .DW(DW)) u_half (
      .clk_i, .rst_ni,
      .clr_i  (clr_v[h]),
      .we_i   (we_v[h]),
      .wdata_i(data_i),
      .raddr_i(rd_addr_i),
      .rdata_o(rdata_v[h]),
      .full_o (full_v[h])
    );
  end

  assign stored = |(we_v & ~full_v);

  anc_pkt_tracker #(.DW(DW), .DC_OFS(DC_OFS)) u_trk (
    .clk_i, .rst_ni,
    .active_i(active),
    .valid_i,
    .stored_i(stored),
    .data_i,
    .detect_o,
    .dc_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsel_q <= 1'b0;
    else         rsel_q <= rsel;
  end

  assign rd_data_o = rdata_v[rsel_q];
  assign full_o    = full_v;

  assert_read_half_not_written_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_WB_RA || phase == PH_WA_RB) |-> !we_v[rsel]);
  assert_single_writer_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(we_v));
  assert_bypass_drops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11) |=> !(|we_v));
endmodule

// File: tb/sim_anc_pingpong_buf.sv
module sim_anc_pingpong_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1024;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       switch_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       ext_en_i = 1'b1;
  logic       valid_i = 1'b0;
  logic [9:0] data_i = '0;
  logic [9:0] rd_addr_i = '0;
  logic [9:0] rd_data_o;
  logic       detect_o;
  logic [1:0] full_o;
  logic [9:0] dc_o;
  logic       err_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // requirement-level model
  logic [9:0] mdl [2][DEPTH];
  int  mcnt [2];
  int  mph = 0;
  bit  m_act = 1'b0;
  logic [9:0] m_dc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  anc_pingpong_buf u0 (
    .clk_i(clk), .rst_ni, .switch_i, .mode_i, .ext_en_i, .valid_i, .data_i,
    .rd_addr_i, .rd_data_o, .detect_o, .full_o, .dc_o, .err_o
  );

  function automatic int m_wr();
    return (mph == 1 || mph == 2) ? 1 : 0;
  endfunction
  function automatic int m_rd();
    return (mph >= 2) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic m_push(input logic [9:0] d, input int idx);
    int w;
    w = m_wr();
    if (m_act && mcnt[w] < DEPTH) begin
      mdl[w][mcnt[w]] = d;
      mcnt[w]++;
      if (idx == 3) m_dc = d;
    end
  endtask

  task automatic m_step();
    mph = (mph + 1) % 4;
    if (mph == 1 || mph == 0) mcnt[1] = 0;
    else                      mcnt[0] = 0;
  endtask

  task automatic send_pkt(input int n, input int seed, input bit chk_det);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 1 && chk_det) chk("R10 detect during packet", detect_o, 1);
      valid_i = 1'b1;
      data_i  = 10'((seed + i * 7) & 10'h3ff);
      m_push(data_i, i);
    end
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    if (chk_det) chk("R10 detect after packet", detect_o, 0);
  endtask

  task automatic rd_chk(input string req, input int a);
    int h;
    @(negedge clk);
    rd_addr_i = 10'(a);
    @(negedge clk);
    h = m_rd();
    chk(req, rd_data_o, (a < mcnt[h]) ? int'(mdl[h][a]) : 0);
  endtask

  task automatic step(input string req, input bit exp_err);
    @(negedge clk);
    switch_i = ~switch_i;
    m_step();
    @(negedge clk);
    chk(req, err_o, exp_err);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R2 reset full", full_o, 0);
    chk("R10 reset detect", detect_o, 0);
    chk("R9 reset err", err_o, 0);
    chk("R11 reset dc", dc_o, 0);
    rd_chk("R13 reset read zero", 0);
  endtask

  task automatic t_reenable();
    idle(100);
    send_pkt(5, 10'h0a0, 1'b0);
    rd_chk("R8 word before delay dropped", 0);
    chk("R10 no detect while idle", detect_o, 0);
    idle(2300);
    m_act = 1'b1;
    send_pkt(6, 10'h100, 1'b1);
    for (int a = 0; a < 6; a++) rd_chk("R13 first half read", a);
    chk("R11 data count latched", dc_o, m_dc);
  endtask

  task automatic t_fill();
    send_pkt(DEPTH, 10'h013, 1'b0);
    chk("R2 first half full", full_o, 2'b01);
    rd_chk("R2 word after start", 6);
    rd_chk("R2 last address", DEPTH - 1);
    chk("R11 dc from long packet", dc_o, m_dc);
  endtask

  task automatic t_phase1();
    step("R1 rising step no err", 1'b0);
    send_pkt(4, 10'h200, 1'b0);
    chk("R3 first half still full", full_o, 2'b01);
    rd_chk("R3 first half unchanged", 0);
    rd_chk("R3 first half tail", DEPTH - 1);
  endtask

  task automatic t_phase2();
    idle(1200);
    step("R1 falling step no err", 1'b0);
    chk("R4 first half cleared", full_o, 2'b00);
    rd_chk("R4 read second half at 0", 0);
    send_pkt(3, 10'h2a0, 1'b0);
    rd_chk("R4 write appended", 4);
    rd_chk("R4 write appended end", 6);
    rd_chk("R12 unwritten reads zero", 7);
  endtask

  task automatic t_phase3();
    idle(1200);
    step("R5 step no err", 1'b0);
    send_pkt(3, 10'h300, 1'b0);
    rd_chk("R5 second half still read", 0);
    rd_chk("R5 second half kept", 6);
  endtask

  task automatic t_phase4();
    idle(1200);
    step("R6 step no err", 1'b0);
    rd_chk("R6 first half new word", 0);
    rd_chk("R12 stale word reads zero", 1000);
    send_pkt(2, 10'h155, 1'b0);
    rd_chk("R6 write continues first half", 3);
    rd_chk("R6 write continues first half end", 4);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    ext_en_i = 1'b0;
    send_pkt(1, 10'h1e1, 1'b0);
    rd_chk("R7 enable low does not stop", 5);
    @(negedge clk);
    mode_i = 2'b11;
    m_act  = 1'b0;
    send_pkt(1, 10'h1f1, 1'b1);
    rd_chk("R7 bypass drops word", 6);
    @(negedge clk);
    mode_i = 2'b00;
    idle(2300);
    send_pkt(1, 10'h1f5, 1'b0);
    rd_chk("R8 enable low keeps off", 6);
    @(negedge clk);
    ext_en_i = 1'b1;
    m_act    = 1'b1;
    send_pkt(1, 10'h1f9, 1'b0);
    rd_chk("R8 resumes with enable", 6);
  endtask

  task automatic t_err();
    idle(1200);
    step("R9 spaced step no err", 1'b0);
    idle(10);
    step("R9 early step flagged", 1'b1);
    idle(1200);
    @(negedge clk);
    valid_i = 1'b1;
    data_i  = 10'h0aa;
    m_push(data_i, 0);
    @(negedge clk);
    switch_i = ~switch_i;
    data_i   = 10'h0ab;
    m_push(data_i, 1);
    m_step();
    @(negedge clk);
    chk("R9 step during detect flagged", err_o, 1);
    valid_i = 1'b0;
    @(negedge clk);
    chk("R9 err is a pulse", err_o, 0);
  endtask

  initial begin
    mcnt[0] = 0;
    mcnt[1] = 0;
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_reenable();
    t_fill();
    t_phase1();
    t_phase2();
    t_phase3();
    t_phase4();
    t_bypass();
    t_err();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule